// File: doc/BRIEF.md
# Unfolding Bipolar PWM Modulator

This block drives the single bidirectional H-bridge on the secondary side of an isolated AC/AC converter. The primary bridges put a 50% duty, envelope-shaped square wave on the medium-frequency transformer. This modulator picks the leg state of the secondary bridge, so that the bridge rectifies that square wave and applies sine-weighted bipolar PWM in the same action. The bridge output is the transformer voltage when the leg state is forward and its negation when the leg state is reverse. The low-frequency output fundamental therefore follows the modulating wave scaled by the virtual-DC envelope, for example a 60 Hz output from a 50 Hz grid.

A polarity signal from the primary timing marks each half-period of the square wave. Every polarity edge restarts an internal carrier counter and latches a new duty sample. The duty sample is signed, and it is clamped to a 12-bit fraction of the half-period. In the first part of each half-period the bridge output is positive, and for the rest it is negative. During a negative transformer half the leg pattern is mirrored, so the output sequence is the same in both halves. The block never switches the bridge itself. Each new leg state goes out as a request to the downstream commutation sequencer and stays on its outputs until that sequencer acknowledges it.

The request controller has three states. `ST_OFF` follows reset and holds the bridge idle until the first polarity edge. It moves to `ST_REQ` as soon as a leg state is wanted. `ST_REQ` presents the request and goes to `ST_HOLD` on the acknowledge. `ST_HOLD` keeps the acknowledged leg state and goes back to `ST_REQ` when the wanted leg state differs from it.

Top module: `unfold_pwm_mod`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_valid` is 0 and `leg_req` is 2'b00.
- R2: Until the first change of `sq_pol` after reset, no request is raised and `leg_req` stays 2'b00.
- R3: After the first polarity edge, `leg_req` only takes the values 2'b10 (forward: S1 on, S2 off, bridge output equals transformer voltage) and 2'b01 (reverse: S1 off, S2 on, bridge output is the negated transformer voltage). It is never 2'b11.
- R4: In a half-period with `sq_pol`=1, the carrier count c runs from 0 at the edge cycle. The wanted leg is forward while c*4096 < D*HALF_CYC and reverse afterwards. This gives forward for ceil(D*HALF_CYC/4096) cycles. With the acknowledge returned at once, `leg_req` shows the decision for count c one clock after the counter holds c.
- R5: In a half-period with `sq_pol`=0, the leg pattern is mirrored: reverse first for the same number of cycles, then forward.
- R6: Every change of `sq_pol` restarts the carrier at 0. A half-period shorter than HALF_CYC is cut short, and the next one starts afresh. The carrier saturates at HALF_CYC if no edge comes.
- R7: The duty value is captured in the cycle of the polarity edge. Changes of `duty_in` within a half-period have no effect on that half-period.
- R8: `duty_in` is two's complement. Negative values act as D=0 (the whole half in the second pattern). Values above 4095 act as D=4095 (the whole half in the first pattern).
- R9: While `req_valid` is 1 and `req_ack` is 0, `req_valid` and `leg_req` stay unchanged, even if the wanted leg changes. In the cycle after an acknowledge, `req_valid` is 0. If the wanted leg then differs, a new request appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sq_pol | input | 1 | Transformer square-wave polarity, 1 = positive half |
| duty_in | input | DIN_W | Signed duty sample, 4096 = one half-period |
| req_ack | input | 1 | Acknowledge from the commutation sequencer |
| req_valid | output | 1 | A leg-state request is pending |
| leg_req | output | 2 | Requested leg state {S1, S2} |

## Verification
The duty is swept over half, quarter, an odd value, zero, full scale, a negative sample and a sample above full scale, each in both polarities. This separates the mirrored pattern from the direct one and separates rounding from clamping at both ends. A half-period cut short by an early polarity edge tells a carrier that restarts apart from one that free-runs. A duty change in mid-half shows whether the sample is latched. With the acknowledge withheld while the wanted leg changes, holding the request can be told apart from retargeting it. Counting the cycles to the first request checks the latency through the counter and the controller.

// File: rtl/umpwm_pkg.sv
package umpwm_pkg;

    // Leg state of the secondary bridge, bit 1 = S1, bit 0 = S2
    typedef enum logic [1:0] {
        LEG_OFF = 2'b00,
        LEG_FWD = 2'b10,
        LEG_REV = 2'b01
    } leg_t;

    // Request controller states
    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_HOLD = 2'b01,
        ST_REQ  = 2'b10
    } req_state_t;

endpackage

// File: rtl/umpwm_duty_sat.sv
module umpwm_duty_sat #(
    parameter int DIN_W = 14,
    parameter int D_W   = 12
) (
    input  logic [DIN_W-1:0] duty_raw,
    output logic [D_W-1:0]   duty_sat
);
    localparam logic [DIN_W-2:0] MAG_MAX = (DIN_W-1)'((1 << D_W) - 1);

    generate
        if (DIN_W - 1 > D_W) begin : g_wide
            always_comb begin
                if (duty_raw[DIN_W-1])
                    duty_sat = '0;
                else if (duty_raw[DIN_W-2:0] > MAG_MAX)
                    duty_sat = '1;
                else
                    duty_sat = duty_raw[D_W-1:0];
            end
        end else begin : g_exact
            // magnitude field cannot exceed full scale, only the sign clamps
            always_comb begin
                if (duty_raw[DIN_W-1])
                    duty_sat = '0;
                else
                    duty_sat = D_W'(duty_raw[DIN_W-2:0]);
            end
        end
    endgenerate

endmodule

// File: rtl/umpwm_carrier.sv
module umpwm_carrier #(
    parameter int HALF_CYC = 1000,
    parameter int D_W      = 12,
    parameter int CNT_W    = $clog2(HALF_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sq_pol,
    input  logic [D_W-1:0]   duty_sat,
    output logic             pol_edge,
    output logic [CNT_W-1:0] cnt,
    output logic [D_W-1:0]   d_lat,
    output logic             half_pos,
    output logic             started
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_CYC);

    logic pol_q;

    assign pol_edge = sq_pol ^ pol_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q    <= 1'b0;
            cnt      <= '0;
            d_lat    <= '0;
            half_pos <= 1'b0;
            started  <= 1'b0;
        end else begin
            pol_q <= sq_pol;
            if (pol_edge) begin
                cnt      <= '0;
                d_lat    <= duty_sat;
                half_pos <= sq_pol;
                started  <= 1'b1;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R6: an edge restarts the carrier and takes the new polarity
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        pol_edge |=> (cnt == '0) && (half_pos == $past(sq_pol)));

    // R6: the carrier steps by one between edges until it saturates
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!pol_edge && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

    // R7: duty stays latched within a half-period
    a_r7_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
        !pol_edge |=> $stable(d_lat));

endmodule

// File: rtl/umpwm_leg_select.sv
module umpwm_leg_select
    import umpwm_pkg::*;
#(
    parameter int HALF_CYC = 1000,
    parameter int D_W      = 12,
    parameter int CNT_W    = $clog2(HALF_CYC + 1)
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [D_W-1:0]   d_lat,
    input  logic             half_pos,
    input  logic             started,
    output leg_t             want
);
    localparam int CMP_W = CNT_W + D_W;

    logic [CMP_W-1:0] lead;
    logic [CMP_W-1:0] limit;
    logic             in_first;

    // scaled carrier against duty times half-period, no divider needed
    assign lead     = {cnt, {D_W{1'b0}}};
    assign limit    = CMP_W'(d_lat) * CMP_W'(HALF_CYC);
    assign in_first = lead < limit;

    always_comb begin
        if (!started)
            want = LEG_OFF;
        else if (in_first == half_pos)
            want = LEG_FWD;
        else
            want = LEG_REV;
    end

endmodule

// File: rtl/umpwm_req_fsm.sv
module umpwm_req_fsm
    import umpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  leg_t want,
    input  logic req_ack,
    output logic req_valid,
    output leg_t leg_req
);
    req_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:  if (want != LEG_OFF) state_nxt = ST_REQ;
            ST_HOLD: if (want != leg_req) state_nxt = ST_REQ;
            ST_REQ:  if (req_ack)         state_nxt = ST_HOLD;
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            leg_req <= LEG_OFF;
        else if (state != ST_REQ && want != leg_req)
            leg_req <= want;
    end

    always_comb req_valid = (state == ST_REQ);

    // R9: pending request is frozen until acknowledged
    a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> req_valid && $stable(leg_req));

    // R9: request drops right after the acknowledge
    a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> !req_valid);

    // R3: a requested state always has exactly one leg on
    a_r3_legs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot(leg_req));

endmodule

// File: rtl/unfold_pwm_mod.sv
module unfold_pwm_mod
    import umpwm_pkg::*;
#(
    parameter int HALF_CYC = 1000,
    parameter int DIN_W    = 14,
    parameter int D_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sq_pol,
    input  logic [DIN_W-1:0] duty_in,
    input  logic             req_ack,
    output logic             req_valid,
    output logic [1:0]       leg_req
);
    localparam int CNT_W = $clog2(HALF_CYC + 1);
    localparam logic [D_W-1:0] D_FULL = '1;

    logic [D_W-1:0]   duty_sat;
    logic             pol_edge;
    logic [CNT_W-1:0] cnt;
    logic [D_W-1:0]   d_lat;
    logic             half_pos;
    logic             started;
    leg_t             want;
    leg_t             leg_q;

    umpwm_duty_sat #(.DIN_W(DIN_W), .D_W(D_W)) u_sat (
        .duty_raw (duty_in),
        .duty_sat (duty_sat)
    );

    umpwm_carrier #(.HALF_CYC(HALF_CYC), .D_W(D_W), .CNT_W(CNT_W)) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .sq_pol   (sq_pol),
        .duty_sat (duty_sat),
        .pol_edge (pol_edge),
        .cnt      (cnt),
        .d_lat    (d_lat),
        .half_pos (half_pos),
        .started  (started)
    );

    umpwm_leg_select #(.HALF_CYC(HALF_CYC), .D_W(D_W), .CNT_W(CNT_W)) u_sel (
        .cnt      (cnt),
        .d_lat    (d_lat),
        .half_pos (half_pos),
        .started  (started),
        .want     (want)
    );

    umpwm_req_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .req_ack   (req_ack),
        .req_valid (req_valid),
        .leg_req   (leg_q)
    );

    assign leg_req = leg_q;

    // R2: bridge stays idle before the first polarity edge
    a_r2_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (!req_valid && leg_req == 2'b00));

    // R8: negative samples clamp to zero duty
    a_r8_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_edge && duty_in[DIN_W-1]) |=> d_lat == '0);

    // R8: oversized samples clamp to full scale
    a_r8_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_edge && !duty_in[DIN_W-1] && duty_in[DIN_W-2:0] > (DIN_W-1)'(D_FULL))
        |=> d_lat == D_FULL);

endmodule

// File: tb/unfold_pwm_mod_tb.sv
module unfold_pwm_mod_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 64;
    localparam int DW_IN      = 14;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             sq_pol;
    logic [DW_IN-1:0] duty_in;
    logic             req_ack;
    logic             req_valid;
    logic [1:0]       leg_req;

    int  checks = 0;
    int  errors = 0;
    bit  ack_auto = 1'b0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unfold_pwm_mod #(.HALF_CYC(HALF), .DIN_W(DW_IN), .D_W(12)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sq_pol    (sq_pol),
        .duty_in   (duty_in),
        .req_ack   (req_ack),
        .req_valid (req_valid),
        .leg_req   (leg_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // forward-then-reverse cycles from the requirement: ceil(D*H/4096), clamped
    function automatic int exp_first(input int duty, input int len);
        int d;
        int t;
        d = duty < 0 ? 0 : (duty > 4095 ? 4095 : duty);
        t = (d * HALF + 4095) / 4096;
        return t < len ? t : len;
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            if (ack_auto) req_ack = req_valid;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; sq_pol = 1'b0; duty_in = '0; req_ack = 1'b0;
        repeat (4) @(negedge clk);
        chk(req_valid == 1'b0 && leg_req == 2'b00, "R1", "reset outputs",
            {req_valid, leg_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0 && leg_req == 2'b00, "R1", "first cycle after reset",
            {req_valid, leg_req}, 0);
    endtask

    task automatic test_idle_before_edge();
        int bad = 0;
        duty_in = DW_IN'(2048);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (req_valid || leg_req != 2'b00) bad++;
        end
        chk(bad == 0, "R2", "idle cycles with request", bad, 0);
    endtask

    // one half-period of len+1 cycles; samples the decisions for counts 0..len-1
    task automatic run_half(input bit pol, input int duty, input int mid,
                            input int len, input string req);
        logic [1:0] fpat;
        logic [1:0] spat;
        int nf = 0;
        int ns = 0;
        int nbad = 0;
        bit seen_s = 1'b0;
        bit order_bad = 1'b0;
        int e;
        fpat = pol ? 2'b10 : 2'b01;
        spat = ~fpat;
        sq_pol  = pol;
        duty_in = DW_IN'(duty);
        @(negedge clk);
        for (int j = 1; j <= len; j++) begin
            @(negedge clk);
            if (leg_req == fpat) begin
                nf++;
                if (seen_s) order_bad = 1'b1;
            end else if (leg_req == spat) begin
                ns++;
                seen_s = 1'b1;
            end else begin
                nbad++;
            end
            if (j == 8) duty_in = DW_IN'(mid);
        end
        e = exp_first(duty, len);
        chk(nf == e, req, "cycles in first pattern", nf, e);
        chk(ns == len - e, req, "cycles in second pattern", ns, len - e);
        chk(!order_bad, req, "first pattern after second", order_bad, 0);
        chk(nbad == 0, "R3", "illegal leg codes", nbad, 0);
    endtask

    // acknowledge withheld while the wanted leg changes
    task automatic test_hold_until_ack();
        int wait_n = 0;
        int bad = 0;
        ack_auto = 1'b0;
        req_ack  = 1'b0;
        sq_pol   = 1'b0;
        duty_in  = DW_IN'(2048);
        while (!req_valid && wait_n < 80) begin
            @(negedge clk);
            wait_n++;
        end
        chk(wait_n == 34, "R4", "cycles from edge to first switch request", wait_n, 34);
        chk(leg_req == 2'b10, "R5", "switch target in negative half", leg_req, 2);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (!req_valid || leg_req != 2'b10) bad++;
        end
        sq_pol  = 1'b1;
        duty_in = DW_IN'(0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!req_valid || leg_req != 2'b10) bad++;
        end
        chk(bad == 0, "R9", "request changed without acknowledge", bad, 0);
        req_ack = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0, "R9", "valid after acknowledge", req_valid, 0);
        req_ack = 1'b0;
        @(negedge clk);
        chk(req_valid == 1'b1 && leg_req == 2'b01, "R9", "retargeted request",
            {req_valid, leg_req}, 5);
        ack_auto = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        do_reset();
        test_idle_before_edge();
        ack_auto = 1'b1;
        run_half(1'b1, 2048, 2048, HALF - 1, "R4");
        run_half(1'b0, 2048, 2048, HALF - 1, "R5");
        run_half(1'b1, 1024, 1024, HALF - 1, "R4");
        run_half(1'b0, 3000, 3000, HALF - 1, "R5");
        run_half(1'b1, 1024, 4000, HALF - 1, "R7");
        run_half(1'b0, 4095, 4095, HALF - 1, "R8");
        run_half(1'b1, 7000, 7000, HALF - 1, "R8");
        run_half(1'b0, -500, -500, HALF - 1, "R8");
        run_half(1'b1, 0, 0, HALF - 1, "R4");
        test_hold_until_ack();
        run_half(1'b0, 2048, 2048, 19, "R6");
        run_half(1'b1, 2048, 2048, HALF - 1, "R6");
        run_half(1'b0, 512, 512, HALF - 1, "R5");
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule